// File: doc/BRIEF.md
# Command Thread Control Register Block

This block holds the software-visible control and status registers for every execution thread of a command-queue engine. Each thread runs a command list on its own core. A simple register bus with a single address, a write strobe and combinational read data reaches every thread's window and one global interrupt summary word. The block turns the thread registers into run, halt and reset requests for each core. It collects the core's halted, waiting, completion, error and fault indications and merges the per-thread interrupts into a single line.

Software starts a thread in a fixed order. It warm-resets the thread, loads the start and end addresses and the priority, enables the interrupts and sets the enable bit. To halt a thread, software writes the suspend register and polls the status register until the halted flag appears. The interrupt service reads the global word, where a pending thread shows a 0 bit. It then clears the thread's interrupt status by writing back the inverse of what it read.

Top module: `cq_thread_regs`

## Requirements
- R1: Thread t occupies the window starting at 0x100 + 0x80*t. Within it the offsets are 0x00 warm reset, 0x04 enable, 0x08 suspend, 0x0C status, 0x10 interrupt status, 0x14 interrupt enable, 0x20 current address, 0x24 end address, 0x30 wait status and 0x40 priority. Unlisted offsets, addresses below 0x100 other than 0x10, and windows of thread indices at or above NUM_THR read 0, and writes to them change nothing.
- R2: Writing 1 to bit 0 at offset 0x00 starts a warm reset. That bit and `thr_reset` read 1 for RST_CYCLES cycles after the write, then clear by themselves.
- R3: A warm reset sets enable, suspend, interrupt status, interrupt enable, current address, end address and priority to 0. While it runs, register writes and core events for that thread are ignored.
- R4: Bit 0 at offset 0x04 is the enable and drives `thr_run`. Bit 0 at offset 0x08 is the suspend request and drives `thr_halt_req`; writing 0 there resumes the thread.
- R5: Bit 1 at offset 0x0C reads 1 when suspend is set and either the core reports halted or the thread is disabled. All other status bits read 0.
- R6: In interrupt status (offset 0x10), a core completion sets bit 0, a core error sets bit 1 and a core fault sets bit 4. A write keeps the bits written as 1 and clears the bits written as 0. An event arriving in the same cycle as that write still sets its bit.
- R7: Interrupt enable (offset 0x14) stores only bits 0, 1 and 4 (mask 0x13). All other bits read 0.
- R8: A thread is pending when any bit of status AND enable is 1. `irq` is 1 while any thread is pending. The global word at address 0x10 has bit t = 0 when thread t is pending and 1 otherwise, and bits at or above NUM_THR read 0.
- R9: A write to offset 0x20 loads the current address. In the next cycle `thr_pc` shows the new value and `thr_pc_load` is 1 for one cycle. Otherwise a core update replaces the address, but a software write in the same cycle wins.
- R10: End address (offset 0x24, 32 bits) and priority (offset 0x40, low PRIO_W bits) are read/write and drive `thr_end` and `thr_prio`.
- R11: Bit 31 at offset 0x30 reads 1 while the core reports waiting and the thread is enabled. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_halted | input | NUM_THR | Core has halted after a suspend request |
| core_waiting | input | NUM_THR | Core is blocked waiting on an event |
| core_done | input | NUM_THR | Completion pulse |
| core_error | input | NUM_THR | Error pulse |
| core_fault | input | NUM_THR | Fault pulse |
| core_pc_upd | input | NUM_THR | Core writes its current address |
| core_pc_val | input | NUM_THR x 32 | Address value from the core |
| thr_run | output | NUM_THR | Run request per thread |
| thr_halt_req | output | NUM_THR | Suspend request per thread |
| thr_reset | output | NUM_THR | Warm reset in progress |
| thr_pc_load | output | NUM_THR | One-cycle strobe after a software address load |
| thr_pc | output | NUM_THR x 32 | Current address per thread |
| thr_end | output | NUM_THR x 32 | End address per thread |
| thr_prio | output | NUM_THR x PRIO_W | Priority per thread |
| irq | output | 1 | Merged interrupt line |

## Verification
Two pairs of functions can land in the same cycle. A core event can arrive together with a software write-to-clear of interrupt status, and a core address update can arrive together with a software load of the current address. The bench drives the core pulse and the bus write in one cycle. It then expects the event bit to survive the clear and the software address to win over the core value. A reference model runs alongside and checks every output and the read data on every clock. The model also covers the warm-reset window, where a write and a core event both land while the reset is running and both must be dropped.

// File: rtl/cqr_pkg.sv
package cqr_pkg;

    localparam int DW            = 32;
    localparam int WIN_SHIFT     = 7;
    localparam int THR_BASE      = 'h100;
    localparam int GLOB_IRQ_ADDR = 'h010;
    localparam int IRQ_W         = 5;
    localparam logic [IRQ_W-1:0] IRQ_KEEP = 5'b10011;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_WRST,
        SEL_EN,
        SEL_SUSP,
        SEL_STAT,
        SEL_ISTA,
        SEL_IEN,
        SEL_PC,
        SEL_END,
        SEL_WAIT,
        SEL_PRIO
    } reg_sel_e;

    typedef struct packed {
        logic fault;
        logic error;
        logic done;
    } core_evt_t;

    function automatic reg_sel_e decode_off(input logic [WIN_SHIFT-1:0] off);
        case (off)
            7'h00:   return SEL_WRST;
            7'h04:   return SEL_EN;
            7'h08:   return SEL_SUSP;
            7'h0C:   return SEL_STAT;
            7'h10:   return SEL_ISTA;
            7'h14:   return SEL_IEN;
            7'h20:   return SEL_PC;
            7'h24:   return SEL_END;
            7'h30:   return SEL_WAIT;
            7'h40:   return SEL_PRIO;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [IRQ_W-1:0] evt_bits(input core_evt_t e);
        return {e.fault, 2'b00, e.error, e.done};
    endfunction

endpackage

// File: rtl/cqr_addr_dec.sv
module cqr_addr_dec
    import cqr_pkg::*;
#(
    parameter int NUM_THR = 16,
    parameter int ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_THR-1:0] thr_hit,
    output reg_sel_e           sel,
    output logic               glob_hit
);
    logic              in_thr;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        in_thr   = addr >= ADDR_W'(THR_BASE);
        rel      = addr - ADDR_W'(THR_BASE);
        idx      = rel >> WIN_SHIFT;
        glob_hit = addr == ADDR_W'(GLOB_IRQ_ADDR);
        sel      = in_thr ? decode_off(addr[WIN_SHIFT-1:0]) : SEL_NONE;
    end

    for (genvar i = 0; i < NUM_THR; i++) begin : g_hit
        assign thr_hit[i] = in_thr && (idx == ADDR_W'(i));
    end
endmodule

// File: rtl/cqr_thread.sv
module cqr_thread
    import cqr_pkg::*;
#(
    parameter int RST_CYCLES = 3,
    parameter int PRIO_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  reg_sel_e          sel,
    input  logic [DW-1:0]     wdata,
    input  core_evt_t         evt,
    input  logic              core_halted,
    input  logic              core_waiting,
    input  logic              core_pc_upd,
    input  logic [DW-1:0]     core_pc_val,
    output logic [DW-1:0]     rd_word,
    output logic              run_o,
    output logic              halt_req_o,
    output logic              reset_o,
    output logic              pc_load_o,
    output logic [DW-1:0]     pc_o,
    output logic [DW-1:0]     end_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic              pend_o
);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    logic [RCW-1:0]    rcnt;
    logic              en_q, susp_q, pcl_q;
    logic [IRQ_W-1:0]  ista_q, ien_q;
    logic [DW-1:0]     pc_q, end_q;
    logic [PRIO_W-1:0] prio_q;
    logic              busy, start, wr_act;

    assign busy   = rcnt != '0;
    assign wr_act = wr_hit && !busy;
    assign start  = wr_act && (sel == SEL_WRST) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt   <= '0;
            en_q   <= 1'b0;
            susp_q <= 1'b0;
            pcl_q  <= 1'b0;
            ista_q <= '0;
            ien_q  <= '0;
            pc_q   <= '0;
            end_q  <= '0;
            prio_q <= '0;
        end else if (busy) begin
            rcnt  <= rcnt - 1'b1;
            pcl_q <= 1'b0;
        end else if (start) begin
            rcnt   <= RCW'(RST_CYCLES);
            en_q   <= 1'b0;
            susp_q <= 1'b0;
            pcl_q  <= 1'b0;
            ista_q <= '0;
            ien_q  <= '0;
            pc_q   <= '0;
            end_q  <= '0;
            prio_q <= '0;
        end else begin
            ista_q <= ((wr_act && sel == SEL_ISTA) ? (ista_q & wdata[IRQ_W-1:0]) : ista_q)
                      | (evt_bits(evt) & IRQ_KEEP);
            if (wr_act && sel == SEL_EN)   en_q   <= wdata[0];
            if (wr_act && sel == SEL_SUSP) susp_q <= wdata[0];
            if (wr_act && sel == SEL_IEN)  ien_q  <= wdata[IRQ_W-1:0] & IRQ_KEEP;
            if (wr_act && sel == SEL_END)  end_q  <= wdata;
            if (wr_act && sel == SEL_PRIO) prio_q <= wdata[PRIO_W-1:0];
            if (wr_act && sel == SEL_PC) begin
                pc_q  <= wdata;
                pcl_q <= 1'b1;
            end else begin
                pcl_q <= 1'b0;
                if (core_pc_upd) pc_q <= core_pc_val;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_WRST: rd_word = {31'b0, busy};
            SEL_EN:   rd_word = {31'b0, en_q};
            SEL_SUSP: rd_word = {31'b0, susp_q};
            SEL_STAT: rd_word = {30'b0, susp_q & (core_halted | ~en_q), 1'b0};
            SEL_ISTA: rd_word = {{(DW-IRQ_W){1'b0}}, ista_q};
            SEL_IEN:  rd_word = {{(DW-IRQ_W){1'b0}}, ien_q};
            SEL_PC:   rd_word = pc_q;
            SEL_END:  rd_word = end_q;
            SEL_WAIT: rd_word = {core_waiting & en_q, 31'b0};
            SEL_PRIO: rd_word = {{(DW-PRIO_W){1'b0}}, prio_q};
            default:  rd_word = '0;
        endcase
    end

    assign run_o      = en_q & ~busy;
    assign halt_req_o = susp_q;
    assign reset_o    = busy;
    assign pc_load_o  = pcl_q;
    assign pc_o       = pc_q;
    assign end_o      = end_q;
    assign prio_o     = prio_q;
    assign pend_o     = |(ista_q & ien_q);

    p_busy_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!en_q && !susp_q && ista_q == '0 && ien_q == '0 && pc_q == '0));

    p_wrst_start_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (reset_o && !run_o));

    p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && evt.done) |=> ista_q[0]);

    p_pc_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_act && !start && sel == SEL_PC) |=> (pc_load_o && pc_o == $past(wdata)));
endmodule

// File: rtl/cqr_irq_merge.sv
module cqr_irq_merge
    import cqr_pkg::*;
#(
    parameter int NUM_THR = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] pend,
    output logic [DW-1:0]      glob_o,
    output logic               irq_o
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i < NUM_THR) begin : g_live
            assign glob_o[i] = ~pend[i];
        end else begin : g_zero
            assign glob_o[i] = 1'b0;
        end
    end

    assign irq_o = |pend;

    p_glob_irq_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o == (glob_o[NUM_THR-1:0] != {NUM_THR{1'b1}}));
endmodule

// File: rtl/cq_thread_regs.sv
module cq_thread_regs
    import cqr_pkg::*;
#(
    parameter int NUM_THR    = 16,
    parameter int ADDR_W     = 12,
    parameter int RST_CYCLES = 3,
    parameter int PRIO_W     = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_THR-1:0]             core_halted,
    input  logic [NUM_THR-1:0]             core_waiting,
    input  logic [NUM_THR-1:0]             core_done,
    input  logic [NUM_THR-1:0]             core_error,
    input  logic [NUM_THR-1:0]             core_fault,
    input  logic [NUM_THR-1:0]             core_pc_upd,
    input  logic [NUM_THR-1:0][31:0]       core_pc_val,
    output logic [NUM_THR-1:0]             thr_run,
    output logic [NUM_THR-1:0]             thr_halt_req,
    output logic [NUM_THR-1:0]             thr_reset,
    output logic [NUM_THR-1:0]             thr_pc_load,
    output logic [NUM_THR-1:0][31:0]       thr_pc,
    output logic [NUM_THR-1:0][31:0]       thr_end,
    output logic [NUM_THR-1:0][PRIO_W-1:0] thr_prio,
    output logic                           irq
);
    logic [NUM_THR-1:0] thr_hit;
    logic [NUM_THR-1:0] pend;
    logic               glob_hit;
    reg_sel_e           sel;
    logic [DW-1:0]      glob_word;
    logic [DW-1:0]      rd_word [NUM_THR];

    cqr_addr_dec #(.NUM_THR(NUM_THR), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .thr_hit  (thr_hit),
        .sel      (sel),
        .glob_hit (glob_hit)
    );

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        core_evt_t ev;
        assign ev = '{fault: core_fault[i], error: core_error[i], done: core_done[i]};

        cqr_thread #(.RST_CYCLES(RST_CYCLES), .PRIO_W(PRIO_W)) u_thr (
            .clk          (clk),
            .rst          (rst),
            .wr_hit       (bus_wr && thr_hit[i]),
            .sel          (sel),
            .wdata        (bus_wdata),
            .evt          (ev),
            .core_halted  (core_halted[i]),
            .core_waiting (core_waiting[i]),
            .core_pc_upd  (core_pc_upd[i]),
            .core_pc_val  (core_pc_val[i]),
            .rd_word      (rd_word[i]),
            .run_o        (thr_run[i]),
            .halt_req_o   (thr_halt_req[i]),
            .reset_o      (thr_reset[i]),
            .pc_load_o    (thr_pc_load[i]),
            .pc_o         (thr_pc[i]),
            .end_o        (thr_end[i]),
            .prio_o       (thr_prio[i]),
            .pend_o       (pend[i])
        );
    end

    cqr_irq_merge #(.NUM_THR(NUM_THR)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .glob_o (glob_word),
        .irq_o  (irq)
    );

    always_comb begin
        bus_rdata = glob_hit ? glob_word : '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (thr_hit[i]) bus_rdata = bus_rdata | rd_word[i];
        end
    end

    p_one_window_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(thr_hit) && !(glob_hit && thr_hit != '0));
endmodule

// File: tb/cq_thread_regs_bench.sv
module cq_thread_regs_bench;
    localparam int NT = 4;
    localparam int RC = 3;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic               bus_wr = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NT-1:0]      core_halted = '0, core_waiting = '0, core_done = '0;
    logic [NT-1:0]      core_error = '0, core_fault = '0, core_pc_upd = '0;
    logic [NT-1:0][31:0] core_pc_val = '0;
    logic [NT-1:0]      thr_run, thr_halt_req, thr_reset, thr_pc_load;
    logic [NT-1:0][31:0] thr_pc, thr_end;
    logic [NT-1:0][PW-1:0] thr_prio;
    logic               irq;

    cq_thread_regs #(.NUM_THR(NT), .ADDR_W(12), .RST_CYCLES(RC), .PRIO_W(PW)) u_cq_thread_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_halted(core_halted), .core_waiting(core_waiting),
        .core_done(core_done), .core_error(core_error), .core_fault(core_fault),
        .core_pc_upd(core_pc_upd), .core_pc_val(core_pc_val),
        .thr_run(thr_run), .thr_halt_req(thr_halt_req), .thr_reset(thr_reset),
        .thr_pc_load(thr_pc_load), .thr_pc(thr_pc), .thr_end(thr_end),
        .thr_prio(thr_prio), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    int unsigned m_en[NT], m_sp[NT], m_ista[NT], m_ien[NT], m_pc[NT];
    int unsigned m_end[NT], m_pr[NT], m_rc[NT], m_pcl[NT];

    bit          x_on = 0;
    string       x_tag;
    logic [31:0] x_val;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit m_pend(int t);
        return (m_ista[t] & m_ien[t]) != 0;
    endfunction

    function automatic logic [31:0] rd_exp(logic [11:0] a);
        logic [31:0] r;
        int t, off;
        r = 0;
        if (a == 12'h010) begin
            for (int k = 0; k < NT; k++) r[k] = !m_pend(k);
            return r;
        end
        if (a < 12'h100) return 0;
        t = (int'(a) - 'h100) / 'h80;
        off = int'(a) % 'h80;
        if (t >= NT) return 0;
        case (off)
            'h00: r = (m_rc[t] > 0) ? 1 : 0;
            'h04: r = m_en[t];
            'h08: r = m_sp[t];
            'h0C: r = (m_sp[t] != 0 && (core_halted[t] || m_en[t] == 0)) ? 2 : 0;
            'h10: r = m_ista[t];
            'h14: r = m_ien[t];
            'h20: r = m_pc[t];
            'h24: r = m_end[t];
            'h30: r = (core_waiting[t] && m_en[t] != 0) ? 32'h8000_0000 : 0;
            'h40: r = m_pr[t];
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string rtag(logic [11:0] a);
        if (a == 12'h010) return "R8";
        if (a < 12'h100 || (int'(a) - 'h100) / 'h80 >= NT) return "R1";
        case (int'(a) % 'h80)
            'h00: return "R2";
            'h04, 'h08: return "R4";
            'h0C: return "R5";
            'h10: return "R6";
            'h14: return "R7";
            'h20: return "R9";
            'h24, 'h40: return "R10";
            'h30: return "R11";
            default: return "R1";
        endcase
    endfunction

    task automatic compare();
        bit any;
        any = 0;
        for (int t = 0; t < NT; t++) begin
            any |= m_pend(t);
            chk($sformatf("R4 run t%0d", t), 32'(thr_run[t]), (m_en[t] != 0 && m_rc[t] == 0) ? 1 : 0);
            chk($sformatf("R4 halt t%0d", t), 32'(thr_halt_req[t]), m_sp[t]);
            chk($sformatf("R2 reset t%0d", t), 32'(thr_reset[t]), (m_rc[t] > 0) ? 1 : 0);
            chk($sformatf("R9 pcload t%0d", t), 32'(thr_pc_load[t]), m_pcl[t]);
            chk($sformatf("R9 pc t%0d", t), thr_pc[t], m_pc[t]);
            chk($sformatf("R10 end t%0d", t), thr_end[t], m_end[t]);
            chk($sformatf("R10 prio t%0d", t), 32'(thr_prio[t]), m_pr[t]);
        end
        chk("R8 irq", 32'(irq), 32'(any));
        chk({rtag(bus_addr), " rdata"}, bus_rdata, rd_exp(bus_addr));
    endtask

    task automatic model_upd();
        int t, off;
        bit hit;
        for (int k = 0; k < NT; k++) begin
            if (rst) begin
                m_en[k] = 0; m_sp[k] = 0; m_ista[k] = 0; m_ien[k] = 0; m_pc[k] = 0;
                m_end[k] = 0; m_pr[k] = 0; m_rc[k] = 0; m_pcl[k] = 0;
                continue;
            end
            t = (int'(bus_addr) - 'h100) / 'h80;
            off = int'(bus_addr) % 'h80;
            hit = bus_wr && bus_addr >= 12'h100 && t == k;
            m_pcl[k] = 0;
            if (m_rc[k] > 0) begin
                m_rc[k]--;
            end else if (hit && off == 'h00 && bus_wdata[0]) begin
                m_rc[k] = RC;
                m_en[k] = 0; m_sp[k] = 0; m_ista[k] = 0; m_ien[k] = 0;
                m_pc[k] = 0; m_end[k] = 0; m_pr[k] = 0;
            end else begin
                if (hit && off == 'h10) m_ista[k] = m_ista[k] & bus_wdata;
                if (core_done[k])  m_ista[k] |= 1;
                if (core_error[k]) m_ista[k] |= 2;
                if (core_fault[k]) m_ista[k] |= 16;
                m_ista[k] &= 'h13;
                if (hit && off == 'h04) m_en[k] = bus_wdata[0];
                if (hit && off == 'h08) m_sp[k] = bus_wdata[0];
                if (hit && off == 'h14) m_ien[k] = bus_wdata & 'h13;
                if (hit && off == 'h24) m_end[k] = bus_wdata;
                if (hit && off == 'h40) m_pr[k] = bus_wdata & ((1 << PW) - 1);
                if (hit && off == 'h20) begin
                    m_pc[k] = bus_wdata;
                    m_pcl[k] = 1;
                end else if (core_pc_upd[k]) begin
                    m_pc[k] = core_pc_val[k];
                end
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        if (x_on) chk(x_tag, bus_rdata, x_val);
        x_on = 0;
        model_upd();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [11:0] ta(int t, int off);
        return 12'('h100 + t * 'h80 + off);
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0;
    endtask

    task automatic expect_rd(string tag, logic [11:0] a, logic [31:0] e);
        bus_addr = a; x_on = 1; x_tag = tag; x_val = e;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; step(); step(); rst = 0;
        expect_rd("R8 global after reset", 12'h010, 32'h0000_000F);
        expect_rd("R4 enable after reset", ta(1, 'h04), 0);

        wr(ta(1, 'h04), 1);
        wr(ta(1, 'h20), 32'h1000);
        wr(ta(1, 'h24), 32'h1040);
        wr(ta(1, 'h40), 32'hFF);
        wr(ta(1, 'h14), 32'hFFFF_FFFF);
        expect_rd("R10 prio", ta(1, 'h40), 7);
        expect_rd("R7 ien mask", ta(1, 'h14), 32'h13);
        expect_rd("R10 end", ta(1, 'h24), 32'h1040);
        expect_rd("R9 pc", ta(1, 'h20), 32'h1000);

        // R6 / R8: completion, global word, inverted-value clear
        core_done[1] = 1; step(); core_done[1] = 0;
        expect_rd("R6 done bit", ta(1, 'h10), 1);
        expect_rd("R8 global pending", 12'h010, 32'h0000_000D);
        wr(ta(1, 'h10), 32'hFFFF_FFFE);
        expect_rd("R6 cleared", ta(1, 'h10), 0);
        // R6 collision: error arrives with clear write
        core_error[1] = 1; wr(ta(1, 'h10), 0); core_error[1] = 0;
        expect_rd("R6 event beats clear", ta(1, 'h10), 2);
        wr(ta(1, 'h10), 32'hFFFF_FFFD);
        core_fault[1] = 1; step(); core_fault[1] = 0;
        wr(ta(1, 'h10), 32'h10);
        expect_rd("R6 kept bit", ta(1, 'h10), 32'h10);
        wr(ta(1, 'h10), 0);
        expect_rd("R8 global idle", 12'h010, 32'h0000_000F);

        // R5 suspend handshake
        wr(ta(1, 'h08), 1);
        expect_rd("R5 not yet halted", ta(1, 'h0C), 0);
        core_halted[1] = 1;
        expect_rd("R5 halted", ta(1, 'h0C), 2);
        wr(ta(1, 'h08), 0);
        expect_rd("R5 resumed", ta(1, 'h0C), 0);
        core_halted[1] = 0;
        wr(ta(2, 'h08), 1);
        expect_rd("R5 disabled suspends at once", ta(2, 'h0C), 2);
        wr(ta(2, 'h08), 0);

        // R11 wait status
        core_waiting[1] = 1; core_waiting[2] = 1;
        expect_rd("R11 waiting enabled", ta(1, 'h30), 32'h8000_0000);
        expect_rd("R11 waiting disabled", ta(2, 'h30), 0);
        core_waiting = '0;

        // R9 core update and collision
        core_pc_upd[1] = 1; core_pc_val[1] = 32'h1008; step(); core_pc_upd[1] = 0;
        expect_rd("R9 core update", ta(1, 'h20), 32'h1008);
        core_pc_upd[1] = 1; core_pc_val[1] = 32'h2222;
        wr(ta(1, 'h20), 32'h3000); core_pc_upd[1] = 0;
        expect_rd("R9 software wins", ta(1, 'h20), 32'h3000);

        // R8 enable gating
        wr(ta(3, 'h14), 32'h10);
        core_done[3] = 1; step(); core_done[3] = 0;
        expect_rd("R8 masked done", 12'h010, 32'h0000_000F);
        core_fault[3] = 1; step(); core_fault[3] = 0;
        expect_rd("R8 fault pending", 12'h010, 32'h0000_0007);
        wr(ta(3, 'h10), 0);

        // R2 / R3 warm reset
        core_done[1] = 1; step(); core_done[1] = 0;
        wr(ta(1, 'h00), 1);
        expect_rd("R2 busy", ta(1, 'h00), 1);
        wr(ta(1, 'h04), 1);
        core_done[1] = 1; step(); core_done[1] = 0;
        expect_rd("R2 self-cleared", ta(1, 'h00), 0);
        expect_rd("R3 enable", ta(1, 'h04), 0);
        expect_rd("R3 pc", ta(1, 'h20), 0);
        expect_rd("R3 ien", ta(1, 'h14), 0);
        expect_rd("R3 ista", ta(1, 'h10), 0);
        expect_rd("R3 prio", ta(1, 'h40), 0);
        expect_rd("R3 end", ta(1, 'h24), 0);

        // R1 decoding
        wr(ta(3, 'h24), 32'hABC);
        expect_rd("R1 window 3", 12'h2A4, 32'hABC);
        wr(ta(5, 'h04), 1);
        expect_rd("R1 out of range", ta(5, 'h04), 0);
        expect_rd("R1 low hole", 12'h018, 0);
        wr(ta(0, 'h18), 32'h55);
        expect_rd("R1 unlisted offset", ta(0, 'h18), 0);
        step();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule